// File: doc/BRIEF.md
# Parallel Port DMA Request Controller

This block drives the DMA request line for the byte FIFO of an extended-capabilities parallel port when data flows from the FIFO to the host. It raises the request while the FIFO has data, DMA is enabled and the service bit is clear. It drops the request when the FIFO runs dry, when a terminal count arrives with the acknowledge active, or when a burst reaches its length limit. After a terminal count the block sets the service bit and pulses an interrupt. The request then stays low until software clears the service bit again.

Software starts a transfer by setting the DMA enable and then writing the service bit to 0. It stops a transfer early by writing the service bit to 1 and then dropping the enable. A burst of back-to-back DMA cycles is capped. Once the cap is hit, the request is held off until the acknowledge has been idle for a time fixed by a parameter. The hold-off time is a whole number of clock cycles, rounded up.

Top module: `ppdma_req_ctrl`

## Requirements
- R1: `drq_o` goes to 1 one clock after `dma_en_i`=1, service bit `svc_o`=0 and `fifo_empty_i`=0 are all seen, provided no hold-off is running.
- R2: When `fifo_empty_i`=1 is sampled, `drq_o` is 0 on the next cycle. It returns one clock after `fifo_empty_i` goes back to 0.
- R3: A terminal count (`tc_i`=1) counts only while the acknowledge is active (`dack_n_i`=0) and it coincides with either the acknowledge falling edge or a falling edge of `ior_n_i`. `drq_o` is 0 on the cycle after it. `tc_i` with the acknowledge inactive has no effect.
- R4: A terminal count sets `svc_o` to 1 and makes `tc_irq_o` high for exactly one cycle, both visible one clock later. `drq_o` stays 0 until software writes `svc_o` back to 0.
- R5: A write with `svc_wr_i`=1 loads `svc_wdata_i` into `svc_o` on the next clock, but a terminal count in the same cycle wins and sets it to 1. While `svc_o`=1 or `dma_en_i`=0, `drq_o` is 0.
- R6: The 32nd acknowledge falling edge (`BURST_MAX`) in an unbroken run with `drq_o` high makes `drq_o` 0 on the next cycle.
- R7: After a burst-cap release, `drq_o` stays 0 until `dack_n_i` has been 1 for `HOLD_CYC` = ceil(`HOLD_PS`/`CLK_PS`) consecutive clocks (35 by default). It rises on the clock after that. Any acknowledge activity during the wait restarts the count.
- R8: `fifo_sel_o` equals the inverse of `dack_n_i` combinationally. FIFO access needs no address qualification.
- R9: The burst count returns to zero whenever `drq_o` is released for any reason, so a run that is split by an empty FIFO does not reach the cap.
- R10: After reset, `drq_o`=0, `tc_irq_o`=0 and `svc_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_empty_i | input | 1 | FIFO holds no byte |
| dack_n_i | input | 1 | DMA acknowledge, active low |
| ior_n_i | input | 1 | I/O read strobe, active low |
| tc_i | input | 1 | Terminal count from the host DMA controller |
| dma_en_i | input | 1 | DMA enable control bit |
| svc_wr_i | input | 1 | Software write strobe for the service bit |
| svc_wdata_i | input | 1 | Value written to the service bit |
| drq_o | output | 1 | DMA request |
| tc_irq_o | output | 1 | One-cycle terminal-count interrupt pulse |
| svc_o | output | 1 | Current service bit (1 disables DMA) |
| fifo_sel_o | output | 1 | FIFO access enable, follows the acknowledge |

## Verification
The bench drives exactly 32 strobes in one run and checks that the request drops. A design that counts from one, or that also counts strobes made while the request was low, would release one cycle early or late. It measures the hold-off to the cycle and then repeats it with a single acknowledge pulse in the middle of the window. A timer that does not restart would bring the request back too soon. It splits a 62-strobe run with an empty FIFO, which catches a burst counter that only clears on reset. It raises terminal count through the read strobe while the acknowledge is held low, and again with the acknowledge inactive. This shows whether the qualification is missing or too strict. Finally, a terminal count and a software clear arrive together, and the bench checks that the service bit stays set.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;

   // Whole clock cycles needed to cover a time span, rounded up.
   function automatic int cycles_for(input longint span_ps, input longint clk_ps);
      return int'((span_ps + clk_ps - 1) / clk_ps);
   endfunction

   function automatic int width_for(input int count);
      return (count < 2) ? 1 : $clog2(count);
   endfunction

endpackage

// File: rtl/ppdma_strobe_edge.sv
module ppdma_strobe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic dack_n_i,
   input  logic ior_n_i,
   output logic dack_act_o,
   output logic dack_fall_o,
   output logic ior_fall_o
);
   logic dack_act_q;
   logic ior_n_q;

   assign dack_act_o  = ~dack_n_i;
   assign dack_fall_o = ~dack_n_i & ~dack_act_q;
   assign ior_fall_o  = ~ior_n_i & ior_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dack_act_q <= 1'b0;
         ior_n_q    <= 1'b1;
      end else begin
         dack_act_q <= ~dack_n_i;
         ior_n_q    <= ior_n_i;
      end
   end

   // R3
   ack_edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dack_fall_o |=> !dack_fall_o);

endmodule

// File: rtl/ppdma_burst_limit.sv
module ppdma_burst_limit #(
   parameter int BURST_MAX = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic drq_i,
   input  logic dack_fall_i,
   output logic burst_end_o
);
   localparam int BW = ppdma_pkg::width_for(BURST_MAX);
   localparam logic [BW-1:0] LAST = BW'(BURST_MAX - 1);

   logic [BW-1:0] run_q;

   assign burst_end_o = drq_i & dack_fall_i & (run_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (!drq_i)
         run_q <= '0;
      else if (dack_fall_i)
         run_q <= (run_q == LAST) ? '0 : run_q + 1'b1;
   end

   // R9
   run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !drq_i |=> (run_q == '0));

   // R6
   run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= LAST);

endmodule

// File: rtl/ppdma_holdoff.sv
module ppdma_holdoff #(
   parameter int HOLD_CYC = 35
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic dack_act_i,
   output logic hold_act_o
);
   generate
      if (HOLD_CYC == 0) begin : g_none
         assign hold_act_o = 1'b0;
      end else begin : g_timer
         localparam int HW = ppdma_pkg::width_for(HOLD_CYC + 1);
         localparam logic [HW-1:0] LOAD = HW'(HOLD_CYC);
         logic [HW-1:0] left_q;

         assign hold_act_o = (left_q != '0);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               left_q <= '0;
            else if (start_i || (hold_act_o && dack_act_i))
               left_q <= LOAD;
            else if (hold_act_o)
               left_q <= left_q - 1'b1;
         end

         // R7
         hold_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_act_o && dack_act_i) |=> hold_act_o);

         // R7
         hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            start_i |=> hold_act_o);
      end
   endgenerate

endmodule

// File: rtl/ppdma_req_ctrl.sv
module ppdma_req_ctrl #(
   parameter int     BURST_MAX = 32,
   parameter longint HOLD_PS   = 350000,
   parameter longint CLK_PS    = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fifo_empty_i,
   input  logic dack_n_i,
   input  logic ior_n_i,
   input  logic tc_i,
   input  logic dma_en_i,
   input  logic svc_wr_i,
   input  logic svc_wdata_i,
   output logic drq_o,
   output logic tc_irq_o,
   output logic svc_o,
   output logic fifo_sel_o
);
   localparam int HOLD_CYC = ppdma_pkg::cycles_for(HOLD_PS, CLK_PS);

   generate
      if (BURST_MAX < 2) begin : g_bad_burst
         $error("BURST_MAX must be at least 2");
      end
      if (CLK_PS <= 0) begin : g_bad_clk
         $error("CLK_PS must be positive");
      end
   endgenerate

   logic dack_act, dack_fall, ior_fall;
   logic burst_end, hold_act;
   logic tc_event;
   logic drq_q, irq_q, svc_q;
   logic drq_d, svc_d;

   ppdma_strobe_edge u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .dack_n_i   (dack_n_i),
      .ior_n_i    (ior_n_i),
      .dack_act_o (dack_act),
      .dack_fall_o(dack_fall),
      .ior_fall_o (ior_fall)
   );

   ppdma_burst_limit #(.BURST_MAX(BURST_MAX)) u_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .drq_i      (drq_q),
      .dack_fall_i(dack_fall),
      .burst_end_o(burst_end)
   );

   ppdma_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (burst_end),
      .dack_act_i(dack_act),
      .hold_act_o(hold_act)
   );

   // Terminal count is qualified by an active acknowledge and one strobe edge.
   assign tc_event = tc_i & dack_act & (dack_fall | ior_fall);

   always_comb begin
      svc_d = svc_q;
      if (svc_wr_i) svc_d = svc_wdata_i;
      if (tc_event) svc_d = 1'b1;
   end

   assign drq_d = dma_en_i & ~svc_q & ~fifo_empty_i & ~hold_act
                & ~tc_event & ~burst_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drq_q <= 1'b0;
         irq_q <= 1'b0;
         svc_q <= 1'b0;
      end else begin
         drq_q <= drq_d;
         irq_q <= tc_event;
         svc_q <= svc_d;
      end
   end

   assign drq_o      = drq_q;
   assign tc_irq_o   = irq_q;
   assign svc_o      = svc_q;
   assign fifo_sel_o = ~dack_n_i;

   // R3
   tc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tc_event |=> !drq_o);

   // R4
   irq_sets_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tc_irq_o |-> svc_o);

   // R2
   empty_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty_i |=> !drq_o);

   // R5
   svc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_o || !dma_en_i) |=> !drq_o);

   // R6
   burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst_end |=> !drq_o);

   // R7
   hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_act |=> !drq_o);

   // R8
   always_comb sel_follow_chk: assert (fifo_sel_o == ~dack_n_i);

endmodule

// File: tb/tb_ppdma_req_ctrl.sv
`timescale 1ns/1ps
module tb_ppdma_req_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int BURST = 32;
   localparam int HOLD  = 35;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fifo_empty = 1'b1, dack_n = 1'b1, ior_n = 1'b1, tc = 1'b0;
   logic dma_en = 1'b0, svc_wr = 1'b0, svc_wdata = 1'b0;
   logic drq, irq, svc, fsel;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ppdma_req_ctrl #(.BURST_MAX(BURST), .HOLD_PS(350000), .CLK_PS(CLK_PERIOD*1000)) dut (
      .clk(clk), .rst_n(rst_n), .fifo_empty_i(fifo_empty), .dack_n_i(dack_n),
      .ior_n_i(ior_n), .tc_i(tc), .dma_en_i(dma_en), .svc_wr_i(svc_wr),
      .svc_wdata_i(svc_wdata), .drq_o(drq), .tc_irq_o(irq), .svc_o(svc),
      .fifo_sel_o(fsel)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic one_byte();
      dack_n = 1'b0; tick();
      dack_n = 1'b1; tick();
   endtask

   task automatic svc_write(input logic v);
      svc_wr = 1'b1; svc_wdata = v; tick();
      svc_wr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10 drq", drq, 0);
      chk("R10 irq", irq, 0);
      chk("R10 svc", svc, 0);
   endtask

   task automatic t_start();
      dma_en = 1'b1; tick();
      svc_write(1'b0);
      chk("R1 drq low while empty", drq, 0);
      fifo_empty = 1'b0; tick();
      chk("R1 drq raised", drq, 1);
   endtask

   task automatic t_empty_split();
      for (int i = 0; i < BURST-1; i++) one_byte();
      chk("R9 drq after 31 strobes", drq, 1);
      fifo_empty = 1'b1; tick();
      chk("R2 drq drops on empty", drq, 0);
      fifo_empty = 1'b0; tick();
      chk("R2 drq back with data", drq, 1);
      for (int i = 0; i < BURST-1; i++) one_byte();
      chk("R9 no cap after split run", drq, 1);
      fifo_empty = 1'b1; tick();
      fifo_empty = 1'b0; tick();
   endtask

   task automatic t_tc_dack();
      dack_n = 1'b0; tc = 1'b1; tick();
      chk("R3 drq drops on tc", drq, 0);
      chk("R4 irq pulse", irq, 1);
      chk("R4 svc set", svc, 1);
      dack_n = 1'b1; tc = 1'b0; tick();
      chk("R4 irq single cycle", irq, 0);
      tick(); tick();
      chk("R4 drq held low after tc", drq, 0);
      svc_write(1'b0);
      chk("R5 svc cleared", svc, 0);
      tick();
      chk("R4 drq back after clear", drq, 1);
   endtask

   task automatic t_tc_ior();
      tc = 1'b1; ior_n = 1'b0; tick();
      chk("R3 tc ignored without ack drq", drq, 1);
      chk("R3 tc ignored without ack svc", svc, 0);
      tc = 1'b0; ior_n = 1'b1; tick();
      dack_n = 1'b0; tick();
      chk("R3 drq high with ack held", drq, 1);
      ior_n = 1'b0; tc = 1'b1; tick();
      chk("R3 drq drops on read strobe tc", drq, 0);
      chk("R3 svc set by read strobe tc", svc, 1);
      ior_n = 1'b1; tc = 1'b0; dack_n = 1'b1; tick();
      svc_write(1'b0);
      tick();
      chk("R3 drq restored", drq, 1);
   endtask

   task automatic t_stop();
      svc_write(1'b1);
      chk("R5 svc written 1", svc, 1);
      tick();
      chk("R5 drq off with svc", drq, 0);
      dma_en = 1'b0;
      svc_write(1'b0);
      tick();
      chk("R5 drq off with enable low", drq, 0);
      dack_n = 1'b0; tc = 1'b1; svc_wr = 1'b1; svc_wdata = 1'b0; tick();
      svc_wr = 1'b0; tc = 1'b0; dack_n = 1'b1;
      chk("R5 tc beats software clear", svc, 1);
      tick();
      dma_en = 1'b1;
      svc_write(1'b0);
      tick();
      chk("R5 drq resumes", drq, 1);
   endtask

   task automatic measure_hold(input string req);
      int n = 0;
      while (drq == 1'b0 && n < 100) begin tick(); n++; end
      chk(req, n, HOLD + 1);
   endtask

   task automatic t_burst();
      for (int i = 0; i < BURST-1; i++) one_byte();
      chk("R6 drq before 32nd strobe", drq, 1);
      dack_n = 1'b0; tick();
      chk("R6 drq drops at cap", drq, 0);
      repeat (5) tick();
      chk("R7 drq low while ack held", drq, 0);
      dack_n = 1'b1;
      measure_hold("R7 hold-off length");
      for (int i = 0; i < BURST; i++) one_byte();
      chk("R6 second cap", drq, 0);
      repeat (20) tick();
      dack_n = 1'b0; tick();
      chk("R7 drq low mid window", drq, 0);
      dack_n = 1'b1;
      measure_hold("R7 restarted hold-off");
   endtask

   task automatic t_sel();
      dack_n = 1'b0; #1;
      chk("R8 sel active", fsel, 1);
      dack_n = 1'b1; #1;
      chk("R8 sel idle", fsel, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      tick(); tick();
      t_reset();
      rst_n = 1'b1; tick();
      t_start();
      t_empty_split();
      t_tc_dack();
      t_tc_ior();
      t_stop();
      t_burst();
      t_sel();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule